// File: doc/BRIEF.md
# Fetch Translation Squash Filter

This block sits in the fetch stage of a multithreaded core and keeps one outstanding instruction-address translation per hardware thread. When a thread is idle and receives a fetch address, the block rounds that address down to the start of its cache block. It stamps the request with a fresh per-thread tag and sends it to the translation unit. The thread then waits for the answer.

A returning answer is trusted only when four things hold: the thread is still waiting, the tag matches, the block address matches, and the unit is not switched out. A trusted answer without a fault becomes an instruction-cache read for the block. A trusted answer with a fault becomes a fault-carrying no-op at the original fetch address, and the thread is parked until a squash arrives. Any other answer is discarded and counted. A squash sends a thread back to idle with a new PC and forgets what it was waiting for. The request already in flight is not recalled; its answer is filtered out when it returns.

Top module: `fetch_xlat_filter`

## Requirements
- R1: After reset every thread is idle, its tag is 0, no output strobe is high and the drop count is 0.
- R2: A fetch to an idle thread gives, one cycle later, xreq_valid with that thread id. The address has its low 6 bits cleared (64-byte blocks). The tag is one more than that thread's previous tag, so the first tag after reset is 1.
- R3: A fetch to a thread that is not idle produces no translation request.
- R4: A trusted response without a fault gives, one cycle later, creq_valid with the thread id and the block address. The thread then waits on the cache and ignores further fetches.
- R5: A trusted response with a fault gives, one cycle later, fault_valid with the unaligned fetch address and no cache request. The thread then ignores fetches until squashed.
- R6: A response is dropped if the thread is not waiting on translation, if the tag differs, if the address differs, or if switched_out is high. A dropped response produces no cache request and no fault, and the drop count rises by one in the next cycle.
- R7: A squash returns the thread to idle from any state. A later response that carries the squashed request's tag is dropped.
- R8: When a squash and a response for the same thread fall in the same cycle, the squash wins and the response is dropped and counted. When a squash and a fetch for the same thread fall in the same cycle, the fetch is ignored.
- R9: wake is high in the cycle after every response, whether or not it is trusted.
- R10: The 16-bit drop count saturates at 65535.
- R11: Threads are independent: a request pending on one thread does not block or alter another thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch address offered |
| fetch_tid | input | 1 | Thread of the fetch |
| fetch_vaddr | input | 32 | Fetch virtual address |
| squash_valid | input | 1 | Squash with redirect |
| squash_tid | input | 1 | Thread squashed |
| squash_pc | input | 32 | New PC after squash |
| switched_out | input | 1 | Unit switched out; responses dropped |
| xreq_valid | output | 1 | Translation request strobe |
| xreq_tid | output | 1 | Thread of the request |
| xreq_tag | output | 4 | Request tag |
| xreq_vaddr | output | 32 | Block-aligned address |
| xrsp_valid | input | 1 | Translation response strobe |
| xrsp_tid | input | 1 | Thread of the response |
| xrsp_tag | input | 4 | Tag returned |
| xrsp_vaddr | input | 32 | Address returned |
| xrsp_fault | input | 1 | Translation fault |
| creq_valid | output | 1 | Cache read strobe |
| creq_tid | output | 1 | Thread of the cache read |
| creq_addr | output | 32 | Block address to read |
| fault_valid | output | 1 | Fault no-op strobe |
| fault_tid | output | 1 | Thread of the fault no-op |
| fault_pc | output | 32 | PC carried by the fault no-op |
| wake | output | 1 | Wake-up pulse to the core |
| drop_count | output | 16 | Saturating dropped-response count |

## Verification
The risky overlap is a squash and a translation response for the same thread in one cycle. The response is fully correct in tag and address, so only the squash can disqualify it. The bench drives both in one cycle and expects no cache request, a drop count one higher, and an idle thread that takes the next fetch. A squash paired with a fetch on the same edge is provoked the same way; it must produce no translation request.

// File: rtl/fxf_pkg.sv
package fxf_pkg;
    typedef enum logic [1:0] {
        TS_IDLE       = 2'd0,
        TS_XLAT_WAIT  = 2'd1,
        TS_CACHE_WAIT = 2'd2,
        TS_TRAP_PEND  = 2'd3
    } tstate_e;
endpackage

// File: rtl/fxf_align.sv
module fxf_align #(
    parameter int VADDR_W     = 32,
    parameter int BLOCK_BYTES = 64
) (
    input  logic [VADDR_W-1:0] addr_in,
    output logic [VADDR_W-1:0] addr_out
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);

    always_comb begin
        addr_out = {addr_in[VADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end
endmodule

// File: rtl/fxf_sat_counter.sv
module fxf_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
    assert_drop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));
endmodule

// File: rtl/fxf_thread.sv
module fxf_thread
    import fxf_pkg::*;
#(
    parameter int VADDR_W = 32,
    parameter int TAG_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_hit,
    input  logic [VADDR_W-1:0] fetch_vaddr,
    input  logic [VADDR_W-1:0] fetch_block,
    input  logic               squash_hit,
    input  logic [VADDR_W-1:0] squash_pc,
    input  logic               rsp_hit,
    input  logic [TAG_W-1:0]   rsp_tag,
    input  logic [VADDR_W-1:0] rsp_vaddr,
    input  logic               rsp_fault,
    input  logic               switched_out,
    output logic               take,
    output logic [TAG_W-1:0]   next_tag,
    output logic               match,
    output logic               drop,
    output logic [VADDR_W-1:0] block_addr,
    output logic [VADDR_W-1:0] cur_pc
);
    typedef struct packed {
        tstate_e            st;
        logic               rec;
        logic [TAG_W-1:0]   tag;
        logic [VADDR_W-1:0] addr;
        logic [VADDR_W-1:0] pc;
    } thr_t;

    thr_t s_d, s_q;

    always_comb begin
        take     = fetch_hit && (s_q.st == TS_IDLE) && !squash_hit;
        next_tag = s_q.tag + 1'b1;
        match    = rsp_hit && (s_q.st == TS_XLAT_WAIT) && s_q.rec &&
                   (rsp_tag == s_q.tag) && (rsp_vaddr == s_q.addr) &&
                   !switched_out && !squash_hit;
        drop     = rsp_hit && !match;

        s_d = s_q;
        if (squash_hit) begin
            s_d.st  = TS_IDLE;
            s_d.rec = 1'b0;
            s_d.pc  = squash_pc;
        end else if (take) begin
            s_d.st   = TS_XLAT_WAIT;
            s_d.rec  = 1'b1;
            s_d.tag  = next_tag;
            s_d.addr = fetch_block;
            s_d.pc   = fetch_vaddr;
        end else if (match) begin
            if (rsp_fault) begin
                s_d.st  = TS_TRAP_PEND;
                s_d.rec = 1'b0;
            end else begin
                s_d.st  = TS_CACHE_WAIT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= TS_IDLE;
            s_q.rec  <= 1'b0;
            s_q.tag  <= '0;
            s_q.addr <= '0;
            s_q.pc   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign block_addr = s_q.addr;
    assign cur_pc     = s_q.pc;

    assert_squash_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        squash_hit |=> (s_q.st == TS_IDLE && !s_q.rec));
    assert_match_leaves_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (s_q.st == TS_CACHE_WAIT || s_q.st == TS_TRAP_PEND));
    assert_busy_no_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != TS_IDLE) |-> !take);
endmodule

// File: rtl/fetch_xlat_filter.sv
module fetch_xlat_filter #(
    parameter int NUM_THREADS = 2,
    parameter int VADDR_W     = 32,
    parameter int BLOCK_BYTES = 64,
    parameter int TAG_W       = 4,
    parameter int CNT_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic [TID_W-1:0]   fetch_tid,
    input  logic [VADDR_W-1:0] fetch_vaddr,
    input  logic               squash_valid,
    input  logic [TID_W-1:0]   squash_tid,
    input  logic [VADDR_W-1:0] squash_pc,
    input  logic               switched_out,
    output logic               xreq_valid,
    output logic [TID_W-1:0]   xreq_tid,
    output logic [TAG_W-1:0]   xreq_tag,
    output logic [VADDR_W-1:0] xreq_vaddr,
    input  logic               xrsp_valid,
    input  logic [TID_W-1:0]   xrsp_tid,
    input  logic [TAG_W-1:0]   xrsp_tag,
    input  logic [VADDR_W-1:0] xrsp_vaddr,
    input  logic               xrsp_fault,
    output logic               creq_valid,
    output logic [TID_W-1:0]   creq_tid,
    output logic [VADDR_W-1:0] creq_addr,
    output logic               fault_valid,
    output logic [TID_W-1:0]   fault_tid,
    output logic [VADDR_W-1:0] fault_pc,
    output logic               wake,
    output logic [CNT_W-1:0]   drop_count
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);

    typedef struct packed {
        logic               xreq_valid;
        logic [TID_W-1:0]   xreq_tid;
        logic [TAG_W-1:0]   xreq_tag;
        logic [VADDR_W-1:0] xreq_vaddr;
        logic               creq_valid;
        logic [TID_W-1:0]   creq_tid;
        logic [VADDR_W-1:0] creq_addr;
        logic               fault_valid;
        logic [TID_W-1:0]   fault_tid;
        logic [VADDR_W-1:0] fault_pc;
        logic               wake;
    } out_t;

    out_t o_d, o_q;

    logic [VADDR_W-1:0] fetch_block;
    logic [NUM_THREADS-1:0] th_take, th_match, th_drop;
    logic [TAG_W-1:0]   th_next_tag [NUM_THREADS];
    logic [VADDR_W-1:0] th_addr     [NUM_THREADS];
    logic [VADDR_W-1:0] th_pc       [NUM_THREADS];
    logic               any_drop;

    fxf_align #(.VADDR_W(VADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_align (
        .addr_in  (fetch_vaddr),
        .addr_out (fetch_block)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        fxf_thread #(.VADDR_W(VADDR_W), .TAG_W(TAG_W)) u_thr (
            .clk          (clk),
            .rst_n        (rst_n),
            .fetch_hit    (fetch_valid && fetch_tid == TID_W'(t)),
            .fetch_vaddr  (fetch_vaddr),
            .fetch_block  (fetch_block),
            .squash_hit   (squash_valid && squash_tid == TID_W'(t)),
            .squash_pc    (squash_pc),
            .rsp_hit      (xrsp_valid && xrsp_tid == TID_W'(t)),
            .rsp_tag      (xrsp_tag),
            .rsp_vaddr    (xrsp_vaddr),
            .rsp_fault    (xrsp_fault),
            .switched_out (switched_out),
            .take         (th_take[t]),
            .next_tag     (th_next_tag[t]),
            .match        (th_match[t]),
            .drop         (th_drop[t]),
            .block_addr   (th_addr[t]),
            .cur_pc       (th_pc[t])
        );
    end

    always_comb begin
        any_drop      = |th_drop;
        o_d           = o_q;
        o_d.xreq_valid  = |th_take;
        o_d.xreq_tid    = fetch_tid;
        o_d.xreq_tag    = th_next_tag[fetch_tid];
        o_d.xreq_vaddr  = fetch_block;
        o_d.creq_valid  = |th_match && !xrsp_fault;
        o_d.creq_tid    = xrsp_tid;
        o_d.creq_addr   = th_addr[xrsp_tid];
        o_d.fault_valid = |th_match && xrsp_fault;
        o_d.fault_tid   = xrsp_tid;
        o_d.fault_pc    = th_pc[xrsp_tid];
        o_d.wake        = xrsp_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    fxf_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (any_drop),
        .count (drop_count)
    );

    assign xreq_valid  = o_q.xreq_valid;
    assign xreq_tid    = o_q.xreq_tid;
    assign xreq_tag    = o_q.xreq_tag;
    assign xreq_vaddr  = o_q.xreq_vaddr;
    assign creq_valid  = o_q.creq_valid;
    assign creq_tid    = o_q.creq_tid;
    assign creq_addr   = o_q.creq_addr;
    assign fault_valid = o_q.fault_valid;
    assign fault_tid   = o_q.fault_tid;
    assign fault_pc    = o_q.fault_pc;
    assign wake        = o_q.wake;

    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(creq_valid && fault_valid));
    assert_wake_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xrsp_valid |=> wake);
    assert_block_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xreq_valid |-> (xreq_vaddr[OFF_W-1:0] == '0));
    assert_no_rsp_no_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !xrsp_valid |=> (!creq_valid && !fault_valid));
endmodule

// File: tb/fetch_xlat_filter_test.sv
module fetch_xlat_filter_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        fetch_valid = 0;
    logic [0:0]  fetch_tid = 0;
    logic [31:0] fetch_vaddr = 0;
    logic        squash_valid = 0;
    logic [0:0]  squash_tid = 0;
    logic [31:0] squash_pc = 0;
    logic        switched_out = 0;
    logic        xreq_valid;
    logic [0:0]  xreq_tid;
    logic [3:0]  xreq_tag;
    logic [31:0] xreq_vaddr;
    logic        xrsp_valid = 0;
    logic [0:0]  xrsp_tid = 0;
    logic [3:0]  xrsp_tag = 0;
    logic [31:0] xrsp_vaddr = 0;
    logic        xrsp_fault = 0;
    logic        creq_valid;
    logic [0:0]  creq_tid;
    logic [31:0] creq_addr;
    logic        fault_valid;
    logic [0:0]  fault_tid;
    logic [31:0] fault_pc;
    logic        wake;
    logic [15:0] drop_count;

    fetch_xlat_filter uut (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    logic [3:0] exp_tag [2] = '{4'd0, 4'd0};
    logic done = 0;

    // bits: [5] exp fault, [4] exp creq, [3] fault, [2] switched, [1] bad addr, [0] bad tag
    localparam logic [5:0] VEC [6] = '{
        6'b010000, 6'b101000, 6'b000001, 6'b000010, 6'b000100, 6'b001001
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_fetch(input logic [0:0] t, input logic [31:0] a, input logic expect_ok, input string req);
        fetch_valid = 1; fetch_tid = t; fetch_vaddr = a;
        tick();
        fetch_valid = 0;
        chk(req, {31'd0, xreq_valid}, {31'd0, expect_ok});
        if (expect_ok) begin
            exp_tag[t] = exp_tag[t] + 4'd1;
            chk({req, " tid"}, {31'd0, xreq_tid}, {31'd0, t});
            chk({req, " tag"}, {28'd0, xreq_tag}, {28'd0, exp_tag[t]});
            chk({req, " addr"}, xreq_vaddr, {a[31:6], 6'd0});
        end
    endtask

    task automatic do_rsp(input logic [0:0] t, input logic [3:0] tg, input logic [31:0] a,
                          input logic flt, input logic ecreq, input logic efault,
                          input logic [31:0] epc, input string req);
        xrsp_valid = 1; xrsp_tid = t; xrsp_tag = tg; xrsp_vaddr = a; xrsp_fault = flt;
        tick();
        xrsp_valid = 0; xrsp_fault = 0;
        if (!ecreq && !efault && exp_cnt < 65535) exp_cnt++;
        chk({req, " creq"}, {31'd0, creq_valid}, {31'd0, ecreq});
        chk({req, " fault"}, {31'd0, fault_valid}, {31'd0, efault});
        chk({req, " count"}, {16'd0, drop_count}, exp_cnt);
        chk("R9 wake after response", {31'd0, wake}, 32'd1);
        if (ecreq) begin
            chk({req, " creq addr"}, creq_addr, a);
            chk({req, " creq tid"}, {31'd0, creq_tid}, {31'd0, t});
        end
        if (efault) begin
            chk({req, " fault pc"}, fault_pc, epc);
            chk({req, " fault tid"}, {31'd0, fault_tid}, {31'd0, t});
        end
    endtask

    task automatic do_squash(input logic [0:0] t, input logic [31:0] pc);
        squash_valid = 1; squash_tid = t; squash_pc = pc;
        tick();
        squash_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] pc0;
        logic [31:0] blk0;
        logic [3:0]  old_tag;
        pc0  = 32'h1234_5678;
        blk0 = 32'h1234_5640;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 xreq idle", {31'd0, xreq_valid}, 32'd0);
        chk("R1 creq idle", {31'd0, creq_valid}, 32'd0);
        chk("R1 fault idle", {31'd0, fault_valid}, 32'd0);
        chk("R1 wake idle", {31'd0, wake}, 32'd0);
        chk("R1 count zero", {16'd0, drop_count}, 32'd0);

        // Table walk: R2, R4, R5, R6 response filtering on thread 0
        for (int i = 0; i < 6; i++) begin
            logic [5:0] v;
            v = VEC[i];
            do_fetch(1'b0, pc0, 1'b1, "R2 fetch to idle");
            do_rsp(1'b0, exp_tag[0] ^ {3'd0, v[0]}, blk0 ^ {25'd0, v[1], 6'd0}, v[3],
                   v[4], v[5], pc0, "R6 table response");
            switched_out = 0;
            do_squash(1'b0, pc0);
            if (i == 3) switched_out = 1;
        end
        switched_out = 0;

        // R3 busy thread ignores fetch
        do_fetch(1'b0, pc0, 1'b1, "R2 fetch");
        do_fetch(1'b0, 32'h0000_1000, 1'b0, "R3 fetch while waiting");
        do_squash(1'b0, pc0);

        // R4 cache wait ignores fetch
        do_fetch(1'b0, pc0, 1'b1, "R2 fetch");
        do_rsp(1'b0, exp_tag[0], blk0, 1'b0, 1'b1, 1'b0, pc0, "R4 good response");
        do_fetch(1'b0, pc0, 1'b0, "R4 fetch in cache wait");
        do_squash(1'b0, pc0);

        // R5 trap pending until squash
        do_fetch(1'b0, 32'h0000_2abc, 1'b1, "R2 fetch");
        do_rsp(1'b0, exp_tag[0], 32'h0000_2a80, 1'b1, 1'b0, 1'b1, 32'h0000_2abc, "R5 fault response");
        do_fetch(1'b0, pc0, 1'b0, "R5 fetch in trap pending");
        do_squash(1'b0, pc0);
        do_fetch(1'b0, pc0, 1'b1, "R5 fetch after squash");
        do_squash(1'b0, pc0);

        // R6 response to idle thread
        do_rsp(1'b1, 4'd1, blk0, 1'b0, 1'b0, 1'b0, 0, "R6 response to idle thread");
        tick();
        chk("R9 wake is a pulse", {31'd0, wake}, 32'd0);

        // R7 stale response after squash, then after refetch
        do_fetch(1'b0, pc0, 1'b1, "R2 fetch");
        old_tag = exp_tag[0];
        do_squash(1'b0, 32'h0000_4000);
        do_rsp(1'b0, old_tag, blk0, 1'b0, 1'b0, 1'b0, 0, "R7 stale after squash");
        do_fetch(1'b0, pc0, 1'b1, "R7 refetch");
        do_rsp(1'b0, old_tag, blk0, 1'b0, 1'b0, 1'b0, 0, "R7 older tag after refetch");
        do_rsp(1'b0, exp_tag[0], blk0, 1'b0, 1'b1, 1'b0, pc0, "R7 current tag accepted");
        do_squash(1'b0, pc0);

        // R8 squash and response in same cycle
        do_fetch(1'b0, pc0, 1'b1, "R2 fetch");
        squash_valid = 1; squash_tid = 0; squash_pc = 32'h0000_8000;
        do_rsp(1'b0, exp_tag[0], blk0, 1'b0, 1'b0, 1'b0, 0, "R8 squash beats response");
        squash_valid = 0;
        do_fetch(1'b0, pc0, 1'b1, "R8 idle after collision");
        do_squash(1'b0, pc0);
        // R8 squash and fetch in same cycle
        squash_valid = 1; squash_tid = 0; squash_pc = pc0;
        do_fetch(1'b0, pc0, 1'b0, "R8 squash beats fetch");
        squash_valid = 0;

        // R11 thread independence
        do_fetch(1'b0, pc0, 1'b1, "R11 fetch t0");
        do_fetch(1'b1, 32'h0abc_def4, 1'b1, "R11 fetch t1 while t0 waits");
        do_rsp(1'b1, exp_tag[1], 32'h0abc_dec0, 1'b0, 1'b1, 1'b0, 0, "R11 t1 response");
        do_rsp(1'b0, exp_tag[0], blk0, 1'b0, 1'b1, 1'b0, pc0, "R11 t0 response");
        do_squash(1'b0, pc0);
        do_squash(1'b1, pc0);

        // R10 saturation: continuous responses to idle thread 1
        xrsp_valid = 1; xrsp_tid = 1; xrsp_tag = 0; xrsp_vaddr = 0;
        repeat (65535 - exp_cnt + 4) tick();
        xrsp_valid = 0;
        exp_cnt = 65535;
        tick();
        chk("R10 count saturated", {16'd0, drop_count}, 32'd65535);
        do_rsp(1'b1, 4'd0, 0, 1'b0, 1'b0, 1'b0, 0, "R10 count stays saturated");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule